// File: doc/BRIEF.md
# Multichannel DAC Serial Command Sequencer

This block sits between a simple request port and the serial control lines of a multichannel DAC. A request can write one channel register, write a batch of channel values and then strobe the load line, or read back one register of one channel. Each request becomes one or more 24-bit serial frames with the correct mode, channel and command fields. The block generates its own serial clock, honours the chip-select gaps that the converter needs, and returns read data with a one-cycle strobe.

The serial clock idles low. Data changes on the rising edge and is sampled on the falling edge. Chip select is active low and stays low for a whole frame. Writes and the read-command frame use one clock rate. The frame that carries read data back uses a second, slower rate, so that data arriving late after a falling edge is still caught. A batch ends with a busy wait of at least 1.5 µs, and then a low pulse on the load line updates all outputs together.

Top module: `dac_frame_seq`

## Requirements
- R1: Every frame is 24 bits, sent most significant bit first. `cs_n` stays low for the whole frame and `sclk` is low whenever `cs_n` is high. `mosi` changes only on a rising `sclk` edge. Each frame has exactly 24 falling `sclk` edges, and the device samples on those falling edges.
- R2: A single write (`req_op`=0) sends one frame: bits [23:22]=2'b11 (data mode), bits [21:16]=channel+8, bits [15:0]=`req_value`. It produces no `ldac_n` pulse.
- R3: A write or read for a channel at or above MAX_CH (40 by default) is refused. So is an undefined operation (`req_op`=3) and a read with `req_regsel`=3. A refused request pulses `err` for one cycle right after the accepting edge, sends no frame, and leaves `req_ready` high.
- R4: A read (`req_op`=2) first sends a command frame: bits [23:22]=0 (special mode), bits [21:16]=5 (readback), bits [15:0]=(`req_regsel`*0x40 + channel + 8) << 7. The `req_regsel` values are 0 = X1A, 1 = X1B, 2 = offset.
- R5: After the read-command frame, `cs_n` stays high for at least READ_GAP_CYC cycles (14 cycles = 280 ns by default). Then an all-zero frame (special-mode NOP) is sent.
- R6: `rd_data` carries the low 16 of the 24 bits sampled from `miso` during the NOP frame. `rd_valid` is high for exactly one cycle, in the cycle after `cs_n` rises at the end of that frame.
- R7: An `sclk` half period is `cfg_wr_half` clock cycles for write frames and for the read-command frame. It is `cfg_rd_half` cycles for the NOP frame of a read. A value of 0 acts as 1. Both values are sampled when a request is accepted.
- R8: `cs_n` falls at least one half period before the first rising `sclk` edge. It rises no sooner than one half period after the last falling edge.
- R9: A batch (`req_op`=1) writes channels 0 to NUM_CH-1 in ascending order. Channel i gets the value `req_batch[16*i+15:16*i]`, in the frame format of R2. `cs_n` stays high for at least INTER_GAP_CYC cycles between frames.
- R10: After the last batch frame, `ldac_n` stays high for at least BUSY_CYC cycles (75 cycles = 1.5 µs by default). It then goes low for exactly LDAC_CYC cycles (4 by default). Only a batch pulses `ldac_n`.
- R11: `req_ready` is low from the accepting edge of a valid request until its last frame and any `ldac_n` pulse are complete. It is high in the idle state and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is accepted when valid and ready are both high |
| req_op | input | 2 | 0 single write, 1 batch, 2 read, 3 undefined |
| req_chan | input | 6 | Channel number for single write or read |
| req_value | input | 16 | Value for a single write |
| req_regsel | input | 2 | Read register type: 0 X1A, 1 X1B, 2 offset |
| req_batch | input | NUM_CH*16 | Batch values, channel i in bits [16*i+15:16*i] |
| cfg_wr_half | input | DIV_W | Serial half period for write frames, in clock cycles |
| cfg_rd_half | input | DIV_W | Serial half period for the read-data frame, in clock cycles |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low frame select |
| ldac_n | output | 1 | Active-low load strobe |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| err | output | 1 | One-cycle refusal strobe |

## Verification
`err` is due in the cycle right after the accepting edge. At that same sample, `req_ready` must be high for a refused request and low for an accepted one. `rd_valid` must appear exactly one cycle after the final rising edge of `cs_n`. The bench's line monitor records the cycle of every `cs_n` and `sclk` transition and compares the distance directly. The gap, busy-wait and lead/trail timings pass through a timer and two register stages, so they are checked as lower bounds rather than exact cycles. High-phase width and `ldac_n` width are exact, so they are compared for equality. All sampling happens on the falling clock edge, half a cycle away from any register update.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam int FRAME_W = 24;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_BATCH = 2'd1,
        OP_READ  = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    // Channel codes in the frame carry an offset of 8.
    function automatic logic [5:0] chan_code(input logic [5:0] ch);
        logic [5:0] c;
        c = ch + 6'd8;
        return c;
    endfunction

    // Data-mode write of one channel register.
    function automatic logic [FRAME_W-1:0] write_frame(input logic [5:0] ch,
                                                       input logic [15:0] val);
        return {2'b11, chan_code(ch), val};
    endfunction

    // Special-mode readback command; select field starts at bit 7.
    function automatic logic [FRAME_W-1:0] read_frame(input logic [5:0] ch,
                                                      input logic [1:0] sel);
        logic [15:0] fld;
        fld = {1'b0, sel, 13'd0} + {3'd0, chan_code(ch), 7'd0};
        return {2'b00, 6'd5, fld};
    endfunction

    localparam logic [FRAME_W-1:0] NOP_FRAME = '0;

endpackage

// File: rtl/dac_wait_timer.sv
module dac_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.run = 1'b1;
            d.cnt = len;
        end else if (q.run) begin
            if (q.cnt <= CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter #(
    parameter int FW      = 24,
    parameter int HW      = 8,
    parameter int RX_KEEP = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FW-1:0]      frame,
    input  logic [HW-1:0]      half,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               done,
    output logic [RX_KEEP-1:0] rx
);
    localparam int BW = $clog2(FW + 1);

    typedef enum logic [1:0] {P_IDLE, P_LEAD, P_HIGH, P_LOW} phase_e;

    typedef struct packed {
        phase_e        ph;
        logic [HW-1:0] half;
        logic [HW-1:0] cnt;
        logic [BW-1:0] nbits;
        logic [FW-1:0] tx;
        logic [FW-1:0] rx;
        logic          sclk;
        logic          mosi;
        logic          cs_n;
        logic          done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            P_IDLE: begin
                if (start) begin
                    d.ph    = P_LEAD;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.half  = half;
                    d.cnt   = half - HW'(1);
                    d.nbits = '0;
                    d.tx    = frame;
                    d.rx    = '0;
                end
            end
            P_LEAD, P_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - HW'(1);
                end else if (q.ph == P_LOW && q.nbits == BW'(FW)) begin
                    d.ph   = P_IDLE;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.ph   = P_HIGH;
                    d.sclk = 1'b1;
                    d.mosi = q.tx[FW-1];
                    d.tx   = {q.tx[FW-2:0], 1'b0};
                    d.cnt  = q.half - HW'(1);
                end
            end
            P_HIGH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - HW'(1);
                end else begin
                    d.ph    = P_LOW;
                    d.sclk  = 1'b0;
                    d.rx    = {q.rx[FW-2:0], miso};
                    d.nbits = q.nbits + BW'(1);
                    d.cnt   = q.half - HW'(1);
                end
            end
            default: d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= P_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
    assign mosi = q.mosi;
    assign cs_n = q.cs_n;
    assign done = q.done;
    assign rx   = q.rx[RX_KEEP-1:0];
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
    import dac_seq_pkg::*;
#(
    parameter int MAX_CH        = 40,  // at most 56 so that channel+8 fits 6 bits
    parameter int NUM_CH        = 4,   // batch size, not above MAX_CH
    parameter int DIV_W         = 8,
    parameter int READ_GAP_CYC  = 14,
    parameter int INTER_GAP_CYC = 2,
    parameter int BUSY_CYC      = 75,
    parameter int LDAC_CYC      = 4    // at least 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [5:0]           req_chan,
    input  logic [15:0]          req_value,
    input  logic [1:0]           req_regsel,
    input  logic [NUM_CH*16-1:0] req_batch,
    input  logic [DIV_W-1:0]     cfg_wr_half,
    input  logic [DIV_W-1:0]     cfg_rd_half,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 ldac_n,
    output logic                 rd_valid,
    output logic [15:0]          rd_data,
    output logic                 err
);
    localparam int T1   = (BUSY_CYC > READ_GAP_CYC) ? BUSY_CYC : READ_GAP_CYC;
    localparam int T2   = (INTER_GAP_CYC > LDAC_CYC) ? INTER_GAP_CYC : LDAC_CYC;
    localparam int TMAX = (T1 > T2) ? T1 : T2;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef enum logic [2:0] {S_IDLE, S_SEND, S_GAP, S_BUSY, S_LOAD} st_e;

    typedef struct packed {
        st_e                  st;
        op_e                  op;
        logic                 rd_phase;
        logic [IDXW-1:0]      idx;
        logic [NUM_CH*16-1:0] vals;
        logic [DIV_W-1:0]     wr_half;
        logic [DIV_W-1:0]     rd_half;
        logic                 sh_start;
        logic [FRAME_W-1:0]   sh_frame;
        logic [DIV_W-1:0]     sh_half;
        logic                 t_start;
        logic [TW-1:0]        t_len;
        logic                 ldac_n;
        logic                 rd_valid;
        logic [15:0]          rd_data;
        logic                 err;
        logic                 ready;
    } seq_t;

    seq_t q, d;

    logic        sh_done;
    logic [15:0] sh_rx;
    logic        t_done;

    function automatic logic [DIV_W-1:0] nz(input logic [DIV_W-1:0] h);
        return (h == '0) ? DIV_W'(1) : h;
    endfunction

    logic ch_ok;
    assign ch_ok = (int'(req_chan) < MAX_CH);

    always_comb begin
        d          = q;
        d.sh_start = 1'b0;
        d.t_start  = 1'b0;
        d.rd_valid = 1'b0;
        d.err      = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid && q.ready) begin
                    d.op      = op_e'(req_op);
                    d.wr_half = nz(cfg_wr_half);
                    d.rd_half = nz(cfg_rd_half);
                    d.sh_half = nz(cfg_wr_half);
                    unique case (op_e'(req_op))
                        OP_WRITE: begin
                            if (ch_ok) begin
                                d.ready    = 1'b0;
                                d.sh_start = 1'b1;
                                d.sh_frame = write_frame(req_chan, req_value);
                                d.st       = S_SEND;
                            end else begin
                                d.err = 1'b1;
                            end
                        end
                        OP_BATCH: begin
                            d.ready    = 1'b0;
                            d.vals     = req_batch;
                            d.idx      = '0;
                            d.sh_start = 1'b1;
                            d.sh_frame = write_frame(6'd0, req_batch[15:0]);
                            d.st       = S_SEND;
                        end
                        OP_READ: begin
                            if (ch_ok && req_regsel != 2'd3) begin
                                d.ready    = 1'b0;
                                d.rd_phase = 1'b0;
                                d.sh_start = 1'b1;
                                d.sh_frame = read_frame(req_chan, req_regsel);
                                d.st       = S_SEND;
                            end else begin
                                d.err = 1'b1;
                            end
                        end
                        default: d.err = 1'b1;
                    endcase
                end
            end
            S_SEND: begin
                if (sh_done) begin
                    unique case (q.op)
                        OP_BATCH: begin
                            d.t_start = 1'b1;
                            if (q.idx == IDXW'(NUM_CH - 1)) begin
                                d.t_len = TW'(BUSY_CYC);
                                d.st    = S_BUSY;
                            end else begin
                                d.idx   = q.idx + IDXW'(1);
                                d.t_len = TW'(INTER_GAP_CYC);
                                d.st    = S_GAP;
                            end
                        end
                        OP_READ: begin
                            if (!q.rd_phase) begin
                                d.t_start = 1'b1;
                                d.t_len   = TW'(READ_GAP_CYC);
                                d.st      = S_GAP;
                            end else begin
                                d.rd_valid = 1'b1;
                                d.rd_data  = sh_rx;
                                d.ready    = 1'b1;
                                d.st       = S_IDLE;
                            end
                        end
                        default: begin
                            d.ready = 1'b1;
                            d.st    = S_IDLE;
                        end
                    endcase
                end
            end
            S_GAP: begin
                if (t_done) begin
                    d.sh_start = 1'b1;
                    d.st       = S_SEND;
                    if (q.op == OP_BATCH) begin
                        d.sh_frame = write_frame(6'(q.idx), q.vals[int'(q.idx)*16 +: 16]);
                        d.sh_half  = q.wr_half;
                    end else begin
                        d.sh_frame = NOP_FRAME;
                        d.sh_half  = q.rd_half;
                        d.rd_phase = 1'b1;
                    end
                end
            end
            S_BUSY: begin
                if (t_done) begin
                    d.ldac_n  = 1'b0;
                    d.t_start = 1'b1;
                    d.t_len   = TW'(LDAC_CYC - 2);
                    d.st      = S_LOAD;
                end
            end
            S_LOAD: begin
                if (t_done) begin
                    d.ldac_n = 1'b1;
                    d.ready  = 1'b1;
                    d.st     = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.op     <= OP_WRITE;
            q.ldac_n <= 1'b1;
            q.ready  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    dac_spi_shifter #(
        .FW     (FRAME_W),
        .HW     (DIV_W),
        .RX_KEEP(16)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .start(q.sh_start),
        .frame(q.sh_frame),
        .half (q.sh_half),
        .miso (miso),
        .sclk (sclk),
        .mosi (mosi),
        .cs_n (cs_n),
        .done (sh_done),
        .rx   (sh_rx)
    );

    dac_wait_timer #(.CW(TW)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .start(q.t_start),
        .len  (q.t_len),
        .done (t_done)
    );

    assign req_ready = q.ready;
    assign ldac_n    = q.ldac_n;
    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rd_data;
    assign err       = q.err;
endmodule

// File: rtl/dac_frame_seq_chk.sv
module dac_frame_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic ldac_n,
    input logic rd_valid,
    input logic err
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                                  // R1
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));                         // R1
    AST_REFUSE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && req_ready));                                     // R3
    AST_RDVALID_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cs_n) && !$past(cs_n, 2)));                   // R6
    AST_LDAC_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> cs_n);                                                // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || !ldac_n) |-> !req_ready);                               // R11
endmodule

bind dac_frame_seq dac_frame_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .ldac_n   (ldac_n),
    .rd_valid (rd_valid),
    .err      (err)
);

// File: tb/dac_frame_seq_bench.sv
module dac_frame_seq_bench;
    localparam int NUM_CH = 4;
    localparam int RGAP   = 14;
    localparam int IGAP   = 2;
    localparam int BUSY   = 75;
    localparam int LDACW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0, req_regsel = '0;
    logic [5:0] req_chan = '0;
    logic [15:0] req_value = '0;
    logic [NUM_CH*16-1:0] req_batch = '0;
    logic [7:0] cfg_wr_half = 8'd4, cfg_rd_half = 8'd7;
    logic sclk, mosi, cs_n, ldac_n, rd_valid, err;
    logic miso = 1'b0;
    logic [15:0] rd_data;

    dac_frame_seq u_dac_frame_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_chan(req_chan), .req_value(req_value),
        .req_regsel(req_regsel), .req_batch(req_batch),
        .cfg_wr_half(cfg_wr_half), .cfg_rd_half(cfg_rd_half),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .ldac_n(ldac_n),
        .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // line monitor state
    int cyc = 0, nfr = 0, bitcnt = 0, cs_fall_cyc = 0, cs_rise_cyc = 0;
    int rise_cyc = 0, last_fall = 0, ldac_fall_cyc = 0, ldac_w = 0, nldac = 0;
    int nrdv = 0, rdv_dist = 0, n_errp = 0;
    logic [23:0] shreg = '0, miso_pat = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_ldac = 1'b1;
    logic [15:0] rd_cap = '0;
    logic [23:0] fr_data [0:7];
    int fr_bits [0:7], fr_gap [0:7], fr_lead [0:7], fr_trail [0:7], fr_hi [0:7];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                cs_fall_cyc = cyc; bitcnt = 0; shreg = '0;
                if (nfr > 0 && nfr < 8) fr_gap[nfr] = cyc - cs_rise_cyc;
            end
            if (!cs_n && sclk && !prev_sclk) begin
                if (bitcnt == 0 && nfr < 8) fr_lead[nfr] = cyc - cs_fall_cyc;
                rise_cyc = cyc;
                miso = (nfr == 1 && bitcnt < 24) ? miso_pat[23 - bitcnt] : 1'b0;
            end
            if (!cs_n && !sclk && prev_sclk) begin
                shreg = {shreg[22:0], mosi};
                bitcnt++;
                if (bitcnt == 1 && nfr < 8) fr_hi[nfr] = cyc - rise_cyc;
                last_fall = cyc;
            end
            if (!prev_cs && cs_n) begin
                if (nfr < 8) begin
                    fr_data[nfr] = shreg; fr_bits[nfr] = bitcnt;
                    fr_trail[nfr] = cyc - last_fall;
                end
                cs_rise_cyc = cyc; nfr++;
            end
            if (prev_ldac && !ldac_n) begin ldac_fall_cyc = cyc; nldac++; end
            if (!prev_ldac && ldac_n) ldac_w = cyc - ldac_fall_cyc;
            if (rd_valid) begin nrdv++; rd_cap = rd_data; rdv_dist = cyc - cs_rise_cyc; end
            if (err) n_errp++;
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_ldac = ldac_n;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_wr(input int ch, input logic [15:0] v);
        return {2'b11, 6'(ch + 8), v};
    endfunction

    function automatic logic [23:0] exp_rd(input int ch, input int sel);
        return {2'b00, 6'd5, 16'((sel * 64 + ch + 8) << 7)};
    endfunction

    function automatic int eff(input logic [7:0] h);
        return (h == 0) ? 1 : int'(h);
    endfunction

    logic err_at_acc, rdy_at_acc;

    task automatic issue(input logic [1:0] op, input int ch, input logic [15:0] v,
                         input int sel, input logic [7:0] wh, input logic [7:0] rh);
        @(negedge clk);
        nfr = 0; nldac = 0; nrdv = 0; n_errp = 0;
        req_op = op; req_chan = 6'(ch); req_value = v; req_regsel = 2'(sel);
        cfg_wr_half = wh; cfg_rd_half = rh; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        err_at_acc = err; rdy_at_acc = req_ready;
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_timing(input int i, input int half, input string req);
        chk(fr_bits[i] == 24, "R1 bit count", fr_bits[i], 24);
        chk(fr_hi[i] == half, {req, " half period"}, fr_hi[i], half);
        chk(fr_lead[i] >= half && fr_trail[i] >= half, "R8 lead/trail",
            (fr_lead[i] < fr_trail[i]) ? fr_lead[i] : fr_trail[i], half);
    endtask

    task automatic do_write(input int ch, input logic [15:0] v, input logic [7:0] wh);
        issue(2'd0, ch, v, 0, wh, 8'd7);
        if (ch >= 40) begin
            chk(err_at_acc && rdy_at_acc && nfr == 0 && n_errp == 1, "R3 refused write",
                nfr, 0);
        end else begin
            chk(!err_at_acc && !rdy_at_acc, "R11 ready low after accept", rdy_at_acc, 0);
            chk(nfr == 1 && fr_data[0] == exp_wr(ch, v), "R2 write frame", fr_data[0],
                exp_wr(ch, v));
            chk(nldac == 0, "R2 no load pulse", nldac, 0);
            frame_timing(0, eff(wh), "R7");
        end
    endtask

    task automatic do_read(input int ch, input int sel, input logic [7:0] wh,
                           input logic [7:0] rh, input logic [23:0] pat);
        miso_pat = pat;
        issue(2'd2, ch, 16'h0, sel, wh, rh);
        if (ch >= 40 || sel == 3) begin
            chk(err_at_acc && rdy_at_acc && nfr == 0 && nrdv == 0, "R3 refused read",
                nfr, 0);
        end else begin
            chk(nfr == 2 && fr_data[0] == exp_rd(ch, sel), "R4 read command frame",
                fr_data[0], exp_rd(ch, sel));
            chk(fr_data[1] == 24'd0, "R5 NOP frame", fr_data[1], 0);
            chk(fr_gap[1] >= RGAP, "R5 readback gap", fr_gap[1], RGAP);
            frame_timing(0, eff(wh), "R7 write");
            frame_timing(1, eff(rh), "R7 read");
            chk(nrdv == 1 && rd_cap == pat[15:0], "R6 read data", rd_cap, pat[15:0]);
            chk(rdv_dist == 1, "R6 strobe timing", rdv_dist, 1);
            chk(nldac == 0, "R10 no load on read", nldac, 0);
        end
    endtask

    task automatic do_batch(input logic [NUM_CH*16-1:0] vals, input logic [7:0] wh);
        req_batch = vals;
        issue(2'd1, 0, 16'h0, 0, wh, 8'd7);
        chk(!rdy_at_acc && !err_at_acc, "R11 ready low in batch", rdy_at_acc, 0);
        chk(nfr == NUM_CH, "R9 frame count", nfr, NUM_CH);
        for (int i = 0; i < NUM_CH; i++) begin
            chk(fr_data[i] == exp_wr(i, vals[16*i +: 16]), "R9 batch frame", fr_data[i],
                exp_wr(i, vals[16*i +: 16]));
            if (i > 0) chk(fr_gap[i] >= IGAP, "R9 inter-frame gap", fr_gap[i], IGAP);
        end
        chk(nldac == 1 && ldac_fall_cyc - cs_rise_cyc >= BUSY, "R10 busy wait",
            ldac_fall_cyc - cs_rise_cyc, BUSY);
        chk(ldac_w == LDACW, "R10 load width", ldac_w, LDACW);
    endtask

    initial begin
        void'($urandom(32'd7531));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && ldac_n && req_ready && !rd_valid && !err,
            "R11 reset state", {cs_n, sclk, ldac_n, req_ready}, 4'b1011);

        do_write(0, 16'hABCD, 8'd4);
        do_write(39, 16'h8001, 8'd0);
        do_write(40, 16'h1234, 8'd2);
        do_write(63, 16'h1234, 8'd2);
        issue(2'd3, 1, 16'h0, 0, 8'd2, 8'd2);
        chk(err_at_acc && rdy_at_acc && nfr == 0, "R3 undefined op", nfr, 0);
        do_read(5, 0, 8'd4, 8'd7, 24'hA5C3_96);
        do_read(39, 2, 8'd1, 8'd15, 24'h12FEDC);
        do_read(3, 1, 8'd2, 8'd0, 24'hFF0001);
        do_read(3, 3, 8'd2, 8'd5, 24'h0);
        do_batch({16'hFFFF, 16'h0000, 16'h8000, 16'h7FFF}, 8'd4);
        do_batch({16'h1111, 16'h2222, 16'h3333, 16'h4444}, 8'd1);

        for (int k = 0; k < 30; k++)
            do_write(int'($urandom % 48), 16'($urandom), 8'($urandom % 7));
        for (int k = 0; k < 12; k++)
            do_read(int'($urandom % 44), int'($urandom % 4), 8'($urandom % 6),
                    8'($urandom % 16), 24'($urandom));
        do_batch({16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)},
                 8'($urandom % 5));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule